// File: doc/BRIEF.md
# Dual Wiper Register Bank Controller

This block keeps the register state of a two-channel digital potentiometer and presents it on a byte-wide register port with an address, write data, a write strobe, a read strobe and registered read data. Each channel has a live 7-bit wiper code, which drives the analog side, and a stored 8-bit start-up value. Five more stored bytes serve as general-purpose scratch space. A control byte sets whether addresses 0 and 1 reach the live wipers or the stored start-up values, holds a run/shutdown control, and reports whether a stored write is still in progress.

The stored cells behave like slow persistent memory. Each accepted write keeps the store busy for a fixed number of cycles, and they are not cleared by reset. After reset the wipers sit at mid-scale (40h) for a set number of cycles and then load the stored start-up values. Wiper code 00h is the end nearest ground and 7Fh the end nearest the supply, and the position rises monotonically with the code. A host-side protocol front end (for example an I2C slave) connects to the register port.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it is released, both wiper outputs are 40h, read data is 00h and the control byte (address 8) holds 40h: bit 7 (volatile select) 0, bit 6 (run) 1, bit 5 (write in progress) 0.
- R2: Wipers stay at 40h until RELOAD_DELAY clock edges with reset high have passed. At the last of these edges each wiper takes bits 6:0 of its stored start-up value. Register-port writes to the wipers before that edge are ignored.
- R3: With control bit 7 at 1, a write to address 0 or 1 changes only that channel's wiper (bits 6:0 of the data) and leaves the stored start-up value unchanged. A read returns the wiper with bit 7 as 0.
- R4: With control bit 7 at 0, an accepted write to address 0 or 1 stores all 8 bits as that channel's start-up value and also loads bits 6:0 into its wiper. A read returns the stored 8-bit value.
- R5: Addresses 2 to 6 are stored 8-bit general-purpose cells. They read and write the same way whatever control bit 7 holds.
- R6: An accepted write to any stored cell sets control bit 5 for the next BUSY_CYCLES clock edges. The bit then clears by itself.
- R7: While bit 5 is set, writes to stored cells are ignored, including the wiper update a start-up value write would make. Reads, writes to the control byte and volatile wiper writes still take effect.
- R8: Stored cells keep their contents across reset, so a start-up value written before reset is what the wiper loads after it.
- R9: Address 7 and addresses 9 to 15 read as 00h. Writes to them change nothing and do not set bit 5.
- R10: Only control bits 7 and 6 are writable. Bit 5 is read-only and bits 4:0 always read 0.
- R11: The shutdown output is 1 whenever control bit 6 is 0 or the active-low shutdown pin is 0, and 0 only when both are 1. It follows the pin in the same cycle.
- R12: Read data is registered. The value for the address presented with the read strobe appears after that clock edge and holds while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| shdn_n_pin | input | 1 | External shutdown request, active low |
| chan_shutdown | output | 1 | 1 = analog channels shut down |
| wiper0 | output | 7 | Channel 0 wiper code |
| wiper1 | output | 7 | Channel 1 wiper code |

## Verification
Writes take effect at the clock edge that samples the strobe, so wiper outputs are checked at the falling edge just after it. Read data for a strobe is sampled at the next falling edge. The write-in-progress window is counted in edges from the accepting write: a stored write at edge W+BUSY_CYCLES must be dropped and one at W+BUSY_CYCLES+1 accepted, and the bench places writes on exactly those edges. The start-up reload is checked at the falling edge after RELOAD_DELAY-1 edges (still 40h) and after RELOAD_DELAY edges (loaded). The shutdown output is combinational and is sampled 1 ns after the pin changes.

// File: rtl/wbk_pkg.sv
// Shared widths, address map and control-bit positions for the wiper bank.
package wbk_pkg;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned WIPER_W = 7;
    localparam int unsigned N_CH    = 2;   // channels; channel i lives at address i
    localparam int unsigned N_CELLS = 7;   // stored cells at addresses 0..6

    localparam logic [ADDR_W-1:0] ADR_RSVD = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_CTL  = 4'd8;

    localparam int unsigned CTL_VOL = 7;   // 1: addresses 0/1 reach live wipers
    localparam int unsigned CTL_RUN = 6;   // 0: channels shut down
    localparam int unsigned CTL_WIP = 5;   // stored write in progress (read-only)

    localparam logic [WIPER_W-1:0] WIPER_MID = 7'h40;
endpackage

// File: rtl/wbk_addr_decode.sv
// Address decoder: turns one register-port write into per-target enables.
// Assumes: wr_en is a single-cycle strobe; busy and loaded come from the
// store and the wiper bank respectively.
module wbk_addr_decode
    import wbk_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               vol_sel,
    input  logic               store_busy,
    input  logic               wipers_loaded,
    output logic [N_CELLS-1:0] cell_we,
    output logic [N_CH-1:0]    wiper_we,
    output logic               ctl_we
);

    genvar gi;
    generate
        for (gi = 0; gi < N_CELLS; gi++) begin : g_cell
            logic hit;
            assign hit = (addr == ADDR_W'(gi));
            if (gi < N_CH) begin : g_shared
                // Shared address: reaches the stored cell only when volatile select is off.
                assign cell_we[gi] = wr_en & hit & ~vol_sel & ~store_busy;
            end else begin : g_plain
                // General-purpose address: always the stored cell.
                assign cell_we[gi] = wr_en & hit & ~store_busy;
            end
        end

        for (gi = 0; gi < N_CH; gi++) begin : g_wiper
            // Wiper written directly (volatile) or mirrored from an accepted stored write.
            assign wiper_we[gi] = wr_en & (addr == ADDR_W'(gi)) & wipers_loaded
                                  & (vol_sel | ~store_busy);
        end
    endgenerate

    // Control byte is volatile and never gated by the busy window.
    assign ctl_we = wr_en & (addr == ADR_CTL);

endmodule

// File: rtl/wbk_persist_store.sv
// Persistent cell array with a fixed write-busy window.
// Assumes: cells model slow non-volatile memory, so rst_n does not clear them;
// their power-on contents come from CELL_INIT (cell i at bits i*8 +: 8).
// BUSY_CYCLES must be at least 1.
module wbk_persist_store
    import wbk_pkg::*;
#(
    parameter int unsigned               BUSY_CYCLES = 20,
    parameter logic [N_CELLS*DATA_W-1:0] CELL_INIT   = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CELLS-1:0]         cell_we,
    input  logic [DATA_W-1:0]          wdata,
    output logic [N_CELLS*DATA_W-1:0]  cells_flat,
    output logic                       busy
);

    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] busy_cnt;

    genvar gi;
    generate
        for (gi = 0; gi < N_CELLS; gi++) begin : g_cell
            logic [DATA_W-1:0] cell_q = CELL_INIT[gi*DATA_W +: DATA_W];
            // Store one byte when its enable is set; contents survive reset.
            always_ff @(posedge clk) begin
                if (cell_we[gi]) begin
                    cell_q <= wdata;
                end
            end
            assign cells_flat[gi*DATA_W +: DATA_W] = cell_q;
        end
    endgenerate

    // Load the busy window on an accepted write and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (|cell_we) begin
            busy_cnt <= CNT_W'(BUSY_CYCLES);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign busy = (busy_cnt != '0);

endmodule

// File: rtl/wbk_wiper_bank.sv
// Live wiper registers with the mid-scale hold and delayed start-up reload.
// Assumes: RELOAD_DELAY >= 2, so the wipers show mid-scale on the first edge
// after reset; ivr_flat carries the stored start-up bytes per channel.
module wbk_wiper_bank
    import wbk_pkg::*;
#(
    parameter int unsigned RELOAD_DELAY = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CH-1:0]           wiper_we,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [N_CH*DATA_W-1:0]    ivr_flat,
    output logic [N_CH*WIPER_W-1:0]   wipers_flat,
    output logic                      loaded
);

    localparam int unsigned CNT_W = $clog2(RELOAD_DELAY + 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             reload_now;

    assign reload_now = !loaded && (wait_cnt == CNT_W'(RELOAD_DELAY - 1));

    // Count edges after reset release and flag the reload edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            loaded   <= 1'b0;
        end else if (reload_now) begin
            loaded   <= 1'b1;
        end else if (!loaded) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_ch
            logic [WIPER_W-1:0] wiper_q;
            // Mid-scale on reset, stored value on reload, port data on a write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wiper_q <= WIPER_MID;
                end else if (reload_now) begin
                    wiper_q <= ivr_flat[gi*DATA_W +: WIPER_W];
                end else if (wiper_we[gi]) begin
                    wiper_q <= wdata[WIPER_W-1:0];
                end
            end
            assign wipers_flat[gi*WIPER_W +: WIPER_W] = wiper_q;
        end
    endgenerate

endmodule

// File: rtl/wbk_ctl_reg.sv
// Volatile control byte: volatile-select and run bits.
// Assumes: the write-in-progress flag is supplied elsewhere and is read-only.
module wbk_ctl_reg
    import wbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              vol_sel,
    output logic              ctl_run
);

    // Capture the two writable bits; reset to stored-access and running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_sel <= 1'b0;
            ctl_run <= 1'b1;
        end else if (ctl_we) begin
            vol_sel <= wdata[CTL_VOL];
            ctl_run <= wdata[CTL_RUN];
        end
    end

endmodule

// File: rtl/wiper_bank_ctrl.sv
// Register bank for a two-channel digital potentiometer behind a byte port.
// Assumes: one access per strobe; read data is registered and valid after
// the edge that samples rd_en; the shutdown output is combinational.
module wiper_bank_ctrl
    import wbk_pkg::*;
#(
    parameter int unsigned               BUSY_CYCLES  = 20,
    parameter int unsigned               RELOAD_DELAY = 8,
    parameter logic [N_CELLS*DATA_W-1:0] CELL_INIT    =
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 8'h40}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr_en,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rdata,
    input  logic               shdn_n_pin,
    output logic               chan_shutdown,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1
);

    logic [N_CELLS*DATA_W-1:0] cells_flat;
    logic [N_CH*WIPER_W-1:0]   wipers_flat;
    logic [N_CELLS-1:0]        cell_we;
    logic [N_CH-1:0]           wiper_we;
    logic                      ctl_we;
    logic                      vol_sel;
    logic                      ctl_run;
    logic                      wip;
    logic                      loaded;
    logic [DATA_W-1:0]         rd_mux;

    wbk_addr_decode u_dec (
        .addr          (addr),
        .wr_en         (wr_en),
        .vol_sel       (vol_sel),
        .store_busy    (wip),
        .wipers_loaded (loaded),
        .cell_we       (cell_we),
        .wiper_we      (wiper_we),
        .ctl_we        (ctl_we)
    );

    wbk_persist_store #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .CELL_INIT   (CELL_INIT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_we    (cell_we),
        .wdata      (wdata),
        .cells_flat (cells_flat),
        .busy       (wip)
    );

    wbk_wiper_bank #(
        .RELOAD_DELAY (RELOAD_DELAY)
    ) u_wipers (
        .clk         (clk),
        .rst_n       (rst_n),
        .wiper_we    (wiper_we),
        .wdata       (wdata),
        .ivr_flat    (cells_flat[N_CH*DATA_W-1:0]),
        .wipers_flat (wipers_flat),
        .loaded      (loaded)
    );

    wbk_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (ctl_we),
        .wdata   (wdata),
        .vol_sel (vol_sel),
        .ctl_run (ctl_run)
    );

    // Select the byte addressed by the port; unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < int'(N_CELLS); i++) begin
            if (addr == ADDR_W'(i)) begin
                rd_mux = cells_flat[i*DATA_W +: DATA_W];
            end
        end
        for (int c = 0; c < int'(N_CH); c++) begin
            if (addr == ADDR_W'(c) && vol_sel) begin
                rd_mux = {1'b0, wipers_flat[c*WIPER_W +: WIPER_W]};
            end
        end
        if (addr == ADR_CTL) begin
            rd_mux[CTL_VOL] = vol_sel;
            rd_mux[CTL_RUN] = ctl_run;
            rd_mux[CTL_WIP] = wip;
        end
    end

    // Register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assign chan_shutdown = ~(ctl_run & shdn_n_pin);
    assign wiper0        = wipers_flat[0*WIPER_W +: WIPER_W];
    assign wiper1        = wipers_flat[1*WIPER_W +: WIPER_W];

endmodule

// File: rtl/wiper_bank_ctrl_checker.sv
// Property checker for wiper_bank_ctrl, attached by bind below.
// Assumes: RELOAD_DELAY >= 2 on the bound instance.
module wiper_bank_ctrl_checker
    import wbk_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         wdata,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [DATA_W-1:0]         rdata,
    input logic                      shdn_n_pin,
    input logic                      chan_shutdown,
    input logic [WIPER_W-1:0]        wiper0,
    input logic [WIPER_W-1:0]        wiper1,
    input logic                      vol_sel,
    input logic                      wip,
    input logic                      loaded,
    input logic [N_CELLS*DATA_W-1:0] cells_flat
);

    assert_mid_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (wiper0 == WIPER_MID && wiper1 == WIPER_MID));

    assert_hold_before_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> (wiper0 == WIPER_MID && wiper1 == WIPER_MID));

    assert_volatile_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && vol_sel && wr_en && addr == 4'd0) |=> (wiper0 == $past(wdata[WIPER_W-1:0])));

    assert_wip_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wr_en));

    assert_busy_blocks_gp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && wr_en && addr >= 4'd2 && addr <= 4'd6) |=> $stable(cells_flat));

    assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_RSVD) |=> ($stable(cells_flat) && $stable(vol_sel)));

    assert_pin_shutdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_pin |-> chan_shutdown);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind wiper_bank_ctrl wiper_bank_ctrl_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wdata         (wdata),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .rdata         (rdata),
    .shdn_n_pin    (shdn_n_pin),
    .chan_shutdown (chan_shutdown),
    .wiper0        (wiper0),
    .wiper1        (wiper1),
    .vol_sel       (vol_sel),
    .wip           (wip),
    .loaded        (loaded),
    .cells_flat    (cells_flat)
);

// File: tb/wiper_bank_ctrl_test.sv
// Directed bench for wiper_bank_ctrl: one task per scenario, each checking itself.
module wiper_bank_ctrl_test;

    localparam int unsigned BUSY   = 20;
    localparam int unsigned RELOAD = 8;
    localparam logic [55:0] INIT   = {8'hA6, 8'hA5, 8'hA4, 8'hA3, 8'hA2, 8'h6A, 8'h11};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       shdn_n_pin = 1'b1;
    logic       chan_shutdown;
    logic [6:0] wiper0;
    logic [6:0] wiper1;

    int tests = 0;
    int fails = 0;

    wiper_bank_ctrl #(
        .BUSY_CYCLES  (BUSY),
        .RELOAD_DELAY (RELOAD),
        .CELL_INIT    (INIT)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .wdata         (wdata),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .rdata         (rdata),
        .shdn_n_pin    (shdn_n_pin),
        .chan_shutdown (chan_shutdown),
        .wiper0        (wiper0),
        .wiper1        (wiper1)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_startup_reload();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", rdata, 8'h00);
        chk("R1 wiper0 in reset", {1'b0, wiper0}, 8'h40);
        chk("R1 wiper1 in reset", {1'b0, wiper1}, 8'h40);
        rst_n = 1'b1;
        do_write(4'd8, 8'hC0);          // edge 1: volatile select
        do_write(4'd0, 8'h33);          // edge 2: wiper write before reload, ignored
        repeat (RELOAD - 3) @(negedge clk);
        chk("R2 wiper0 before reload", {1'b0, wiper0}, 8'h40);
        @(negedge clk);
        chk("R2 wiper0 reloaded", {1'b0, wiper0}, 8'h11);
        chk("R2 wiper1 reloaded", {1'b0, wiper1}, 8'h6A);
    endtask

    task automatic t_reset_ctl();
        logic [7:0] d;
        apply_reset();
        do_read(4'd8, d);
        chk("R1 R10 control byte after reset", d, 8'h40);
        chk("R1 wiper0 first cycle", {1'b0, wiper0}, 8'h40);
        repeat (RELOAD) @(negedge clk);
    endtask

    task automatic t_volatile();
        logic [7:0] d;
        do_write(4'd8, 8'hC0);
        do_write(4'd0, 8'h85);
        chk("R3 wiper0 volatile write", {1'b0, wiper0}, 8'h05);
        do_read(4'd0, d);
        chk("R3 volatile read bit7 zero", d, 8'h05);
        chk("R3 wiper1 untouched", {1'b0, wiper1}, 8'h6A);
        do_write(4'd8, 8'h40);
        do_read(4'd0, d);
        chk("R3 stored value unchanged", d, 8'h11);
    endtask

    task automatic t_mirror_busy();
        logic [7:0] d;
        do_write(4'd1, 8'hF3);          // edge W
        chk("R4 mirrored wiper1", {1'b0, wiper1}, 8'h73);
        do_read(4'd8, d);               // edge W+1
        chk("R6 write in progress", d, 8'h60);
        repeat (BUSY - 2) @(negedge clk);
        do_write(4'd1, 8'h22);          // edge W+BUSY: still busy
        chk("R7 busy write dropped", {1'b0, wiper1}, 8'h73);
        do_write(4'd1, 8'hC4);          // edge W+BUSY+1: accepted
        chk("R4 write after window", {1'b0, wiper1}, 8'h44);
        do_write(4'd8, 8'hC0);
        do_write(4'd0, 8'h12);
        chk("R7 volatile write while busy", {1'b0, wiper0}, 8'h12);
        do_write(4'd8, 8'h40);
        do_read(4'd1, d);
        chk("R4 R7 stored read while busy", d, 8'hC4);
        repeat (BUSY + 2) @(negedge clk);
        do_read(4'd8, d);
        chk("R6 busy cleared", d, 8'h40);
    endtask

    task automatic t_general();
        logic [7:0] d;
        do_read(4'd3, d);
        chk("R5 initial general cell", d, 8'hA3);
        for (int a = 2; a <= 6; a++) begin
            do_write(4'(a), 8'h90 + 8'(a));
            repeat (BUSY + 1) @(negedge clk);
        end
        do_write(4'd8, 8'hC0);
        for (int a = 2; a <= 6; a++) begin
            do_read(4'(a), d);
            chk("R5 general cell readback", d, 8'h90 + 8'(a));
        end
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        do_write(4'd7, 8'hFF);
        do_read(4'd8, d);
        chk("R9 reserved write no effect", d, 8'hC0);
        do_read(4'd7, d);
        chk("R9 reserved reads zero", d, 8'h00);
        do_write(4'd9, 8'h0F);
        do_write(4'd15, 8'h00);
        do_read(4'd9, d);
        chk("R9 unmapped reads zero", d, 8'h00);
        do_read(4'd8, d);
        chk("R9 control unchanged", d, 8'hC0);
        do_read(4'd2, d);
        chk("R9 general cell unchanged", d, 8'h92);
    endtask

    task automatic t_ctl_bits();
        logic [7:0] d;
        do_write(4'd8, 8'h3F);
        do_read(4'd8, d);
        chk("R10 low bits not writable", d, 8'h00);
        do_write(4'd8, 8'hFF);
        do_read(4'd8, d);
        chk("R10 only bits 7 and 6 set", d, 8'hC0);
    endtask

    task automatic t_shutdown();
        do_write(4'd8, 8'h40);
        shdn_n_pin = 1'b1; #1;
        chk("R11 run and pin high", {7'b0, chan_shutdown}, 8'h01 ^ 8'h01);
        shdn_n_pin = 1'b0; #1;
        chk("R11 pin low", {7'b0, chan_shutdown}, 8'h01);
        @(negedge clk);
        do_write(4'd8, 8'h00);
        chk("R11 run low pin low", {7'b0, chan_shutdown}, 8'h01);
        shdn_n_pin = 1'b1; #1;
        chk("R11 run low pin high", {7'b0, chan_shutdown}, 8'h01);
        @(negedge clk);
        do_write(4'd8, 8'h40);
        chk("R11 back to running", {7'b0, chan_shutdown}, 8'h00);
    endtask

    task automatic t_persist();
        logic [7:0] d;
        do_write(4'd0, 8'h2A);
        repeat (BUSY + 2) @(negedge clk);
        apply_reset();
        repeat (RELOAD - 1) @(negedge clk);
        chk("R8 mid-scale before reload", {1'b0, wiper0}, 8'h40);
        @(negedge clk);
        chk("R8 stored value reloaded", {1'b0, wiper0}, 8'h2A);
        do_read(4'd4, d);
        chk("R8 general cell survives reset", d, 8'h94);
    endtask

    task automatic t_read_hold();
        logic [7:0] d;
        do_read(4'd1, d);
        chk("R12 read latency", d, 8'hC4);
        addr = 4'd8;
        repeat (2) @(negedge clk);
        chk("R12 rdata holds without strobe", rdata, 8'hC4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_startup_reload();
        t_reset_ctl();
        t_volatile();
        t_mirror_busy();
        t_general();
        t_reserved();
        t_ctl_bits();
        t_shutdown();
        t_persist();
        t_read_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule